// File: doc/BRIEF.md
# Reorder Buffer with Result Broadcast

This block keeps the in-flight instructions of a small out-of-order core in program order. At dispatch each instruction claims the next slot of a circular buffer, and the slot's index is handed back as the instruction's rename tag. When an execution unit finishes, it writes the result and its fault and mispredict flags into that slot. In the following cycle the block broadcasts the tag and value so that waiting instructions in the issue queue can mark their operands ready.

Results stay in the buffer until the oldest entry has completed cleanly. At that point the entry is retired as a register-file write, at most one per cycle. A fault is held back until its entry becomes the oldest. The block then reports the faulting PC, does not retire the entry, and empties the buffer. A mispredicted branch squashes every younger entry in the same cycle that it completes. The entries older than the branch are kept and retire normally. A flush strobe tells the rename logic when to recover.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: alloc_ready is 1, alloc_tag is 0, and commit_valid, exc_valid, bcast_valid and flush_o are 0.
- R2: The tag handed out equals the slot index. Successive accepted allocations receive 0, 1, ..., DEPTH-1 and then wrap to 0.
- R3: Once DEPTH entries are held, alloc_ready is 0. A request made while full is ignored, so alloc_tag stays unchanged.
- R4: commit_valid is 1 only when the oldest entry has completed without a fault. It then carries that entry's destination register and result. Entries retire strictly oldest first, one per cycle, and younger completed entries wait.
- R5: One cycle after an accepted completion, bcast_valid is 1 with the completing tag and value.
- R6: A completion whose tag is not currently held in the buffer is ignored and produces no broadcast.
- R7: When the oldest entry has completed with a fault, exc_valid is 1 with that entry's PC, flush_o is 1, and commit_valid is 0. On the next cycle the buffer is empty and the next tag issued is the faulting slot's index.
- R8: When a completion has the mispredict flag set (cmpl_mispred = 1) for a held entry, every younger entry is discarded at that edge. The next tag issued is the branch tag plus 1, modulo DEPTH. Completions to discarded tags are ignored, and the branch and older entries retire normally.
- R9: A faulting entry that is not the oldest raises nothing. Older entries retire first.
- R10: In any cycle where flush_o is 1, alloc_ready is 0 and an allocation request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_dest | input | AREG_W | Architectural destination register |
| alloc_pc | input | PC_W | PC of the dispatched instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TW | Tag (slot index) for the request |
| cmpl_valid | input | 1 | A result is being written |
| cmpl_tag | input | TW | Tag of the completing instruction |
| cmpl_value | input | XLEN | Result value |
| cmpl_exc | input | 1 | Instruction faulted |
| cmpl_mispred | input | 1 | Instruction is a mispredicted branch |
| bcast_valid | output | 1 | Result broadcast strobe |
| bcast_tag | output | TW | Broadcast tag |
| bcast_value | output | XLEN | Broadcast value |
| commit_valid | output | 1 | Register-file write of the oldest entry |
| commit_reg | output | AREG_W | Destination register being written |
| commit_value | output | XLEN | Value being written |
| exc_valid | output | 1 | Fault reported for the oldest entry |
| exc_pc | output | PC_W | PC of the faulting instruction |
| flush_o | output | 1 | Younger state is being discarded |

## Verification
Completions are driven in three orders. Youngest first shows that a finished younger entry waits behind an unfinished head. Oldest first shows back-to-back retirement. A full six-entry sweep that starts mid-buffer checks the wrap of tags and of the head past the last slot. A mispredict in the middle of four entries is paired with a stray completion to a squashed slot and a completion to an empty buffer, which tells a true squash apart from stale slots that merely look alive. A fault placed in the second entry, completed before the oldest entry, separates deferred fault handling from immediate handling and shows which tag the refilled buffer starts from.

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH  = 6,
  parameter int XLEN   = 32,
  parameter int PC_W   = 32,
  parameter int AREG_W = 5,
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [AREG_W-1:0] alloc_dest,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [TW-1:0]     alloc_tag,
  input  logic              cmpl_valid,
  input  logic [TW-1:0]     cmpl_tag,
  input  logic [XLEN-1:0]   cmpl_value,
  input  logic              cmpl_exc,
  input  logic              cmpl_mispred,
  output logic              bcast_valid,
  output logic [TW-1:0]     bcast_tag,
  output logic [XLEN-1:0]   bcast_value,
  output logic              commit_valid,
  output logic [AREG_W-1:0] commit_reg,
  output logic [XLEN-1:0]   commit_value,
  output logic              exc_valid,
  output logic [PC_W-1:0]   exc_pc,
  output logic              flush_o
);

  logic [TW-1:0]     head_q, tail_q;
  logic [CW-1:0]     count_q, age_c;
  logic [DEPTH-1:0]  done_q, exc_q;
  logic [AREG_W-1:0] dest_q [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];
  logic [XLEN-1:0]   val_q  [DEPTH];
  logic              head_ready, cmpl_live, mis_flush, take;

  function automatic logic [TW-1:0] wrap_inc(input logic [TW-1:0] t);
    return (t == TW'(DEPTH - 1)) ? '0 : t + 1'b1;
  endfunction

  always_comb begin
    int a;
    a = int'(cmpl_tag) - int'(head_q);
    if (a < 0) a = a + DEPTH;
    age_c = CW'(a);
  end

  assign head_ready   = (count_q != '0) && done_q[head_q];
  assign exc_valid    = head_ready && exc_q[head_q];
  assign commit_valid = head_ready && !exc_q[head_q];
  assign commit_reg   = dest_q[head_q];
  assign commit_value = val_q[head_q];
  assign exc_pc       = pc_q[head_q];

  assign cmpl_live   = cmpl_valid && (int'(cmpl_tag) < DEPTH) && (age_c < count_q) && !exc_valid;
  assign mis_flush   = cmpl_live && cmpl_mispred;
  assign flush_o     = mis_flush || exc_valid;
  assign alloc_ready = (count_q != CW'(DEPTH)) && !flush_o;
  assign alloc_tag   = tail_q;
  assign take        = alloc_valid && alloc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q      <= '0;
      tail_q      <= '0;
      count_q     <= '0;
      done_q      <= '0;
      exc_q       <= '0;
      bcast_valid <= 1'b0;
      bcast_tag   <= '0;
      bcast_value <= '0;
    end else begin
      bcast_valid <= cmpl_live;
      bcast_tag   <= cmpl_tag;
      bcast_value <= cmpl_value;
      if (exc_valid) begin
        tail_q  <= head_q;
        count_q <= '0;
      end else begin
        if (commit_valid) head_q <= wrap_inc(head_q);
        if (mis_flush) begin
          tail_q  <= wrap_inc(cmpl_tag);
          count_q <= age_c + CW'(1) - CW'(commit_valid);
        end else begin
          if (take) tail_q <= wrap_inc(tail_q);
          count_q <= count_q + CW'(take) - CW'(commit_valid);
        end
      end
      if (take) begin
        done_q[tail_q] <= 1'b0;
        exc_q[tail_q]  <= 1'b0;
      end
      if (cmpl_live) begin
        done_q[cmpl_tag] <= 1'b1;
        exc_q[cmpl_tag]  <= cmpl_exc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      dest_q[tail_q] <= alloc_dest;
      pc_q[tail_q]   <= alloc_pc;
    end
    if (cmpl_live) val_q[cmpl_tag] <= cmpl_value;
  end

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 6,
  parameter int TW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [TW-1:0] alloc_tag,
  input logic          cmpl_valid,
  input logic [TW-1:0] cmpl_tag,
  input logic          cmpl_mispred,
  input logic          bcast_valid,
  input logic [TW-1:0] bcast_tag,
  input logic          commit_valid,
  input logic          exc_valid,
  input logic          flush_o
);

  function automatic logic [TW-1:0] nxt(input logic [TW-1:0] t);
    return (t == TW'(DEPTH - 1)) ? '0 : t + 1'b1;
  endfunction

  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready |=> alloc_tag == nxt($past(alloc_tag))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !alloc_ready && !flush_o |=> $stable(alloc_tag)); // R3
  AST_BCAST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> $past(cmpl_valid) && bcast_tag == $past(cmpl_tag)); // R5
  AST_EXC_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_valid && exc_valid)); // R7
  AST_EXC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> alloc_ready && !commit_valid && !exc_valid); // R7
  AST_MISPRED_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid && cmpl_mispred && flush_o && !exc_valid |=> alloc_tag == nxt($past(cmpl_tag))); // R8

endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_tag(alloc_tag), .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
  .cmpl_mispred(cmpl_mispred), .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
  .commit_valid(commit_valid), .exc_valid(exc_valid), .flush_o(flush_o)
);

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [4:0]  alloc_dest = '0;
  logic [31:0] alloc_pc = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        cmpl_valid = 1'b0;
  logic [2:0]  cmpl_tag = '0;
  logic [31:0] cmpl_value = '0;
  logic        cmpl_exc = 1'b0, cmpl_mispred = 1'b0;
  logic        bcast_valid;
  logic [2:0]  bcast_tag;
  logic [31:0] bcast_value;
  logic        commit_valid;
  logic [4:0]  commit_reg;
  logic [31:0] commit_value;
  logic        exc_valid;
  logic [31:0] exc_pc;
  logic        flush_o;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_value(cmpl_value),
    .cmpl_exc(cmpl_exc), .cmpl_mispred(cmpl_mispred),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_value(bcast_value),
    .commit_valid(commit_valid), .commit_reg(commit_reg), .commit_value(commit_value),
    .exc_valid(exc_valid), .exc_pc(exc_pc), .flush_o(flush_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic alloc(input logic [4:0] d, input logic [31:0] pc, input int exp_tag, input string req);
    alloc_valid = 1'b1; alloc_dest = d; alloc_pc = pc;
    #1 chk(req, alloc_tag, exp_tag);
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic cmpl(input logic [2:0] t, input logic [31:0] v, input logic e, input logic m);
    cmpl_valid = 1'b1; cmpl_tag = t; cmpl_value = v; cmpl_exc = e; cmpl_mispred = m;
    tick();
    cmpl_valid = 1'b0; cmpl_exc = 1'b0; cmpl_mispred = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ready", alloc_ready, 1);
    chk("R1 tag", alloc_tag, 0);
    chk("R1 commit", commit_valid, 0);
    chk("R1 exc", exc_valid, 0);
    chk("R1 bcast", bcast_valid, 0);
    chk("R1 flush", flush_o, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 3; i++) alloc(5'(i + 1), 32'h0, i, "R2 tag");
    cmpl(3'd2, 32'h22, 1'b0, 1'b0);
    chk("R5 bcast valid", bcast_valid, 1);
    chk("R5 bcast tag", bcast_tag, 2);
    chk("R5 bcast value", bcast_value, 32'h22);
    chk("R4 younger waits", commit_valid, 0);
    cmpl(3'd0, 32'h10, 1'b0, 1'b0);
    chk("R4 head commit", commit_valid, 1);
    chk("R4 head reg", commit_reg, 1);
    chk("R4 head value", commit_value, 32'h10);
    tick();
    chk("R4 head1 pending", commit_valid, 0);
    cmpl(3'd1, 32'h11, 1'b0, 1'b0);
    chk("R4 reg2", commit_reg, 2);
    chk("R4 val2", commit_value, 32'h11);
    tick();
    chk("R4 back to back", commit_valid, 1);
    chk("R4 reg3", commit_reg, 3);
    chk("R4 val3", commit_value, 32'h22);
    tick();
    chk("R4 drained", commit_valid, 0);
    chk("R2 tail", alloc_tag, 3);
  endtask

  task automatic t_full_wrap();
    for (int i = 0; i < 6; i++) alloc(5'(10 + i), 32'h0, (3 + i) % 6, "R2 wrap tag");
    chk("R3 full ready", alloc_ready, 0);
    alloc_valid = 1'b1; alloc_dest = 5'd9;
    tick();
    alloc_valid = 1'b0;
    chk("R3 ignored tag", alloc_tag, 3);
    chk("R3 still full", alloc_ready, 0);
    for (int i = 0; i < 6; i++) begin
      cmpl(3'((3 + i) % 6), 32'h30 + 32'(i), 1'b0, 1'b0);
      chk("R4 stream valid", commit_valid, 1);
      chk("R4 stream reg", commit_reg, 10 + i);
      chk("R4 stream value", commit_value, 32'h30 + i);
    end
    tick();
    chk("R4 stream empty", commit_valid, 0);
    chk("R2 tail after wrap", alloc_tag, 3);
    chk("R3 ready again", alloc_ready, 1);
  endtask

  task automatic t_mispredict();
    cmpl(3'd3, 32'h99, 1'b0, 1'b0);
    chk("R6 empty completion", bcast_valid, 0);
    for (int i = 0; i < 4; i++) alloc(5'(5 + i), 32'h0, (3 + i) % 6, "R2 tag");
    cmpl_valid = 1'b1; cmpl_tag = 3'd4; cmpl_value = 32'h44; cmpl_mispred = 1'b1;
    alloc_valid = 1'b1; alloc_dest = 5'd20;
    #1;
    chk("R8 flush strobe", flush_o, 1);
    chk("R10 ready low", alloc_ready, 0);
    tick();
    cmpl_valid = 1'b0; cmpl_mispred = 1'b0; alloc_valid = 1'b0;
    chk("R8 next tag", alloc_tag, 5);
    chk("R8 branch bcast", bcast_tag, 4);
    cmpl(3'd0, 32'hAA, 1'b0, 1'b0);
    chk("R8 squashed ignored", bcast_valid, 0);
    cmpl(3'd3, 32'h33, 1'b0, 1'b0);
    chk("R8 older commits", commit_valid, 1);
    chk("R8 older reg", commit_reg, 5);
    tick();
    chk("R8 branch commits", commit_valid, 1);
    chk("R8 branch reg", commit_reg, 6);
    chk("R8 branch value", commit_value, 32'h44);
    tick();
    chk("R8 nothing younger", commit_valid, 0);
    chk("R8 tail kept", alloc_tag, 5);
  endtask

  task automatic t_exception();
    alloc(5'd1, 32'h100, 5, "R2 tag");
    alloc(5'd2, 32'h104, 0, "R2 tag");
    alloc(5'd3, 32'h108, 1, "R2 tag");
    cmpl(3'd0, 32'hE0, 1'b1, 1'b0);
    cmpl(3'd1, 32'hE1, 1'b0, 1'b0);
    chk("R9 deferred", exc_valid, 0);
    chk("R9 no commit", commit_valid, 0);
    cmpl(3'd5, 32'h55, 1'b0, 1'b0);
    chk("R9 older first", commit_valid, 1);
    chk("R9 older value", commit_value, 32'h55);
    chk("R9 not yet", exc_valid, 0);
    tick();
    chk("R7 exc", exc_valid, 1);
    chk("R7 pc", exc_pc, 32'h104);
    chk("R7 no commit", commit_valid, 0);
    chk("R7 flush", flush_o, 1);
    tick();
    chk("R7 cleared", exc_valid, 0);
    chk("R7 empty", commit_valid, 0);
    chk("R7 restart tag", alloc_tag, 0);
    chk("R7 ready", alloc_ready, 1);
    alloc(5'd4, 32'h200, 0, "R7 reuse tag");
    chk("R7 stale done", commit_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 t_reset();
    tick();
    t_order();
    t_full_wrap();
    t_mispredict();
    t_exception();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule